// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits behind the receive half of an Ethernet MAC and moves each incoming frame into memory that software has prepared. Software builds a ring of 16-byte descriptors at a base address. Word 0 of each descriptor is a control/status word, and word 2 (byte offset 8) holds the address of its data buffer. Software hands a descriptor to the hardware by setting the ownership flag (bit 31) and writing the usable buffer size into bits 12:0. Bit 30 marks the last descriptor of the ring.

After reset the block reads the descriptor at the ring base. It keeps reading it until the ownership flag is set, and then reads the buffer address. Each byte of the next frame goes to buffer address plus byte offset, up to the buffer size. When the frame ends, the block writes a status word back to word 0. That word holds the full byte count (frame check bytes included), the per-cause and summary error flags, the preserved end-of-ring flag and a cleared ownership flag. The block then moves to the next descriptor, or returns to the ring base after an end-of-ring descriptor. A frame that begins while no owned descriptor has been fetched is dropped whole and counted.

The descriptor port has a fixed read latency of one cycle. Read data for a request issued in one cycle is presented in the next cycle. Buffer bytes leave on a separate byte-wide write port with no handshake.

Top module: `rxd_ring_writer`

## Requirements
- R1: While reset is held and right after it, no write is issued on either port, `irq_evt_o` is zero and `miss_cnt_o` is zero. The first descriptor read after reset addresses `ring_base_i` exactly.
- R2: Byte i of a received frame (counting from 0) is written to the buffer address read from descriptor byte offset 8, plus i, in arrival order.
- R3: The written-back status word has bit 31 cleared and bit 30 equal to the end-of-ring flag read from the descriptor. Bits 12:0 hold the number of bytes stored, which counts every byte of the frame including the four check bytes.
- R4: `rx_flags_i` is sampled with the last byte. Bit 0 (check-sum error) sets status bit 19, and bit 1 (runt) sets status bit 20. Status bit 21 is set exactly when any of bits 19, 20 or 22 is set.
- R5: Bytes past the buffer limit are not written. The stored length equals the limit, and status bits 22 and 21 are set. A frame exactly as long as the limit sets neither bit.
- R6: After a write-back the next descriptor is read at the current descriptor address plus 16. After a descriptor with bit 30 set, the next one is read at `ring_base_i`.
- R7: Each completed frame raises exactly one one-cycle event on `irq_evt_o`. Bit 0 is raised when status bit 21 is clear, and bit 1 when it is set. At most one event bit is high in any cycle.
- R8: A frame that starts while no owned descriptor is held is dropped. It causes no buffer or status write, a one-cycle pulse on `irq_evt_o` bit 4 and an increment of `miss_cnt_o` by one. The ring index does not move.
- R9: A descriptor found without ownership is re-read until software sets bit 31. The next frame is then written through that descriptor.
- R10: A buffer size field greater than 2048 bytes acts as a limit of 2048.
- R11: A one-byte frame, with valid and last in the same cycle, is stored and written back with length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ring_base_i | input | ADDR_W | Byte address of descriptor 0 |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Marks the final byte of a frame |
| rx_flags_i | input | 2 | Frame errors with the last byte: bit 0 check-sum, bit 1 runt |
| desc_req_o | output | 1 | Descriptor port request |
| desc_we_o | output | 1 | Descriptor port write (status write-back) |
| desc_addr_o | output | ADDR_W | Descriptor port byte address |
| desc_wdata_o | output | 32 | Status word written back |
| desc_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| buf_we_o | output | 1 | Buffer byte write strobe |
| buf_addr_o | output | ADDR_W | Buffer byte address |
| buf_data_o | output | 8 | Buffer byte data |
| irq_evt_o | output | 8 | Event pulses: bit 0 good frame, bit 1 error frame, bit 4 no descriptor |
| miss_cnt_o | output | CNT_W | Dropped-frame count |

## Verification
The assertions assume three things about the environment. The descriptor port returns read data exactly one cycle after each request. `rx_last_i` and `rx_flags_i` are meaningful only together with `rx_valid_i`. A new frame does not begin while a frame is still in flight. The bench's memory model answers every read on the next edge. Its MAC driver sends each frame as an unbroken burst of valid bytes with last and flags on the final byte only. It leaves at least eight idle cycles between frames, so the block is holding a fetched descriptor whenever a frame is meant to be accepted. The only exception is the deliberate drop case, where the frame arrives while the only descriptor on offer is still unowned.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,   // read status word of current descriptor
        ST_STAT,    // status word on read bus, decide
        ST_BUFA,    // buffer address on read bus
        ST_RECV,    // descriptor held, storing bytes
        ST_DROP,    // discarding a frame with no descriptor
        ST_WBACK    // write status word back
    } rxd_state_e;

    localparam int OWN_BIT  = 31;
    localparam int EOR_BIT  = 30;
    localparam int LONG_BIT = 22;
    localparam int SUM_BIT  = 21;
    localparam int RUNT_BIT = 20;
    localparam int FCS_BIT  = 19;

    localparam int EVT_OK     = 0;
    localparam int EVT_ERR    = 1;
    localparam int EVT_NODESC = 4;

endpackage

// File: rtl/rxd_desc_addr.sv
module rxd_desc_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] stat_addr_o,
    output logic [ADDR_W-1:0] bufp_addr_o
);
    localparam int DESC_SHIFT = 4;
    localparam logic [ADDR_W-1:0] BUFP_OFS = ADDR_W'(8);

    logic [ADDR_W-1:0] ofs;

    always_comb begin
        ofs         = {{(ADDR_W-IDX_W-DESC_SHIFT){1'b0}}, idx_i, {DESC_SHIFT{1'b0}}};
        stat_addr_o = base_i + ofs;
        bufp_addr_o = base_i + ofs + BUFP_OFS;
    end
endmodule

// File: rtl/rxd_byte_path.sv
module rxd_byte_path #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic              active_i,
    input  logic              valid_i,
    input  logic [7:0]        data_i,
    input  logic [LEN_W:0]    cnt_i,
    input  logic [LEN_W:0]    lim_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        data_o,
    output logic              store_o,
    output logic              over_o
);
    logic room;

    always_comb begin
        room    = (cnt_i < lim_i);
        store_o = active_i && valid_i && room;
        over_o  = active_i && valid_i && !room;
        we_o    = store_o;
        addr_o  = base_i + {{(ADDR_W-LEN_W-1){1'b0}}, cnt_i};
        data_o  = data_i;
    end
endmodule

// File: rtl/rxd_status_pack.sv
module rxd_status_pack #(
    parameter int LEN_W = 13
) (
    input  logic             eor_i,
    input  logic             long_i,
    input  logic             fcs_i,
    input  logic             runt_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [31:0]      word_o
);
    import rxd_pkg::*;

    always_comb begin
        word_o                = '0;
        word_o[OWN_BIT]       = 1'b0;
        word_o[EOR_BIT]       = eor_i;
        word_o[LONG_BIT]      = long_i;
        word_o[SUM_BIT]       = long_i | fcs_i | runt_i;
        word_o[RUNT_BIT]      = runt_i;
        word_o[FCS_BIT]       = fcs_i;
        word_o[LEN_W-1:0]     = len_i;
    end
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 8,
    parameter int LEN_W     = 13,
    parameter int MAX_FRAME = 2048,
    parameter int CNT_W     = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] ring_base_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    input  logic              rx_last_i,
    input  logic [1:0]        rx_flags_i,
    output logic              desc_req_o,
    output logic              desc_we_o,
    output logic [ADDR_W-1:0] desc_addr_o,
    output logic [31:0]       desc_wdata_o,
    input  logic [31:0]       desc_rdata_i,
    output logic              buf_we_o,
    output logic [ADDR_W-1:0] buf_addr_o,
    output logic [7:0]        buf_data_o,
    output logic [7:0]        irq_evt_o,
    output logic [CNT_W-1:0]  miss_cnt_o
);
    import rxd_pkg::*;

    localparam logic [LEN_W:0] MAX_L = MAX_FRAME[LEN_W:0];

    typedef struct packed {
        rxd_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic [LEN_W:0]    lim;
        logic [LEN_W:0]    cnt;
        logic              eor;
        logic              long_f;
        logic              fcs;
        logic              runt;
        logic [CNT_W-1:0]  miss;
    } regs_t;

    regs_t q, d;

    logic [ADDR_W-1:0] stat_addr, bufp_addr;
    logic              st_we, st_store, st_over;
    logic [31:0]       wb_word;
    logic [LEN_W:0]    size_fld;
    logic              blocked;
    logic              rdata_unused;

    assign rdata_unused = ^desc_rdata_i[EOR_BIT-1:LEN_W];

    rxd_desc_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) addr_i (
        .base_i      (ring_base_i),
        .idx_i       (q.idx),
        .stat_addr_o (stat_addr),
        .bufp_addr_o (bufp_addr)
    );

    rxd_byte_path #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) bytes_i (
        .active_i (q.st == ST_RECV),
        .valid_i  (rx_valid_i),
        .data_i   (rx_data_i),
        .cnt_i    (q.cnt),
        .lim_i    (q.lim),
        .base_i   (q.base),
        .we_o     (st_we),
        .addr_o   (buf_addr_o),
        .data_o   (buf_data_o),
        .store_o  (st_store),
        .over_o   (st_over)
    );

    rxd_status_pack #(.LEN_W(LEN_W)) pack_i (
        .eor_i  (q.eor),
        .long_i (q.long_f),
        .fcs_i  (q.fcs),
        .runt_i (q.runt),
        .len_i  (q.cnt[LEN_W-1:0]),
        .word_o (wb_word)
    );

    always_comb begin
        d          = q;
        desc_req_o = 1'b0;
        desc_we_o  = 1'b0;
        desc_addr_o = stat_addr;
        irq_evt_o  = '0;
        size_fld   = {1'b0, desc_rdata_i[LEN_W-1:0]};
        blocked    = rx_valid_i &&
                     (q.st == ST_FETCH || q.st == ST_STAT || q.st == ST_BUFA);

        if (blocked) begin
            irq_evt_o[EVT_NODESC] = 1'b1;
            d.miss = q.miss + 1'b1;
            d.st   = rx_last_i ? ST_FETCH : ST_DROP;
        end else begin
            unique case (q.st)
                ST_FETCH: begin
                    desc_req_o = 1'b1;
                    d.st       = ST_STAT;
                end
                ST_STAT: begin
                    if (desc_rdata_i[OWN_BIT]) begin
                        d.eor       = desc_rdata_i[EOR_BIT];
                        d.lim       = (size_fld > MAX_L) ? MAX_L : size_fld;
                        desc_req_o  = 1'b1;
                        desc_addr_o = bufp_addr;
                        d.st        = ST_BUFA;
                    end else begin
                        d.st = ST_FETCH;
                    end
                end
                ST_BUFA: begin
                    d.base   = desc_rdata_i[ADDR_W-1:0];
                    d.cnt    = '0;
                    d.long_f = 1'b0;
                    d.fcs    = 1'b0;
                    d.runt   = 1'b0;
                    d.st     = ST_RECV;
                end
                ST_RECV: begin
                    if (st_store) d.cnt = q.cnt + 1'b1;
                    if (st_over)  d.long_f = 1'b1;
                    if (rx_valid_i && rx_last_i) begin
                        d.fcs  = rx_flags_i[0];
                        d.runt = rx_flags_i[1];
                        d.st   = ST_WBACK;
                    end
                end
                ST_DROP: begin
                    if (rx_valid_i && rx_last_i) d.st = ST_FETCH;
                end
                ST_WBACK: begin
                    desc_req_o = 1'b1;
                    desc_we_o  = 1'b1;
                    if (wb_word[SUM_BIT]) irq_evt_o[EVT_ERR] = 1'b1;
                    else                  irq_evt_o[EVT_OK]  = 1'b1;
                    d.idx = q.eor ? '0 : q.idx + 1'b1;
                    d.st  = ST_FETCH;
                end
                default: d.st = ST_FETCH;
            endcase
        end
    end

    assign desc_wdata_o = wb_word;
    assign buf_we_o     = st_we;
    assign miss_cnt_o   = q.miss;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.st     <= ST_FETCH;
            q.idx    <= '0;
            q.base   <= '0;
            q.lim    <= '0;
            q.cnt    <= '0;
            q.eor    <= 1'b0;
            q.long_f <= 1'b0;
            q.fcs    <= 1'b0;
            q.runt   <= 1'b0;
            q.miss   <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/rxd_ring_checker.sv
module rxd_ring_checker #(
    parameter int LEN_W     = 13,
    parameter int MAX_FRAME = 2048,
    parameter int CNT_W     = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             desc_req_o,
    input logic             desc_we_o,
    input logic [31:0]      desc_wdata_o,
    input logic             buf_we_o,
    input logic [7:0]       irq_evt_o,
    input logic [CNT_W-1:0] miss_cnt_o
);
    localparam logic [LEN_W-1:0] MAXV = LEN_W'(MAX_FRAME);

    assert_own_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        desc_we_o |-> !desc_wdata_o[31]);

    assert_len_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        desc_we_o |-> (desc_wdata_o[LEN_W-1:0] <= MAXV));

    assert_summary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (desc_we_o && (desc_wdata_o[19] || desc_wdata_o[20] || desc_wdata_o[22]))
        |-> desc_wdata_o[21]);

    assert_evt_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(irq_evt_o));

    assert_drop_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_evt_o[4] |-> (!buf_we_o && !desc_we_o));

    assert_miss_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (miss_cnt_o != $past(miss_cnt_o)) |-> $past(irq_evt_o[4]));

    assert_port_split_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        buf_we_o |-> !desc_req_o);
endmodule

bind rxd_ring_writer rxd_ring_checker #(
    .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .desc_req_o   (desc_req_o),
    .desc_we_o    (desc_we_o),
    .desc_wdata_o (desc_wdata_o),
    .buf_we_o     (buf_we_o),
    .irq_evt_o    (irq_evt_o),
    .miss_cnt_o   (miss_cnt_o)
);

// File: tb/rxd_ring_writer_tb_top.sv
module rxd_ring_writer_tb_top;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam logic [31:0] RING_BASE = 32'h40;
    localparam int NVEC = 8;

    typedef struct packed {
        logic [15:0] len;
        logic [12:0] size;
        logic        fcs;
        logic        runt;
    } vec_t;

    // len, buffer size, check-sum error, runt
    localparam vec_t VECS [NVEC] = '{
        '{16'd64,   13'd1536, 1'b0, 1'b0},
        '{16'd30,   13'd16,   1'b0, 1'b0},
        '{16'd60,   13'd1536, 1'b1, 1'b0},
        '{16'd20,   13'd1536, 1'b0, 1'b1},
        '{16'd1536, 13'd1536, 1'b0, 1'b0},
        '{16'd1537, 13'd1536, 1'b0, 1'b0},
        '{16'd1,    13'd1536, 1'b0, 1'b0},
        '{16'd100,  13'd1536, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic rx_valid, rx_last;
    logic [7:0] rx_data;
    logic [1:0] rx_flags;
    logic desc_req, desc_we, buf_we;
    logic [ADDR_W-1:0] desc_addr, buf_addr;
    logic [31:0] desc_wdata, desc_rdata;
    logic [7:0] buf_data, irq_evt;
    logic [CNT_W-1:0] miss_cnt;

    logic sw_we;
    logic [5:0] sw_addr;
    logic [31:0] sw_data;

    logic [31:0] desc_mem [64];
    logic [7:0]  bufm [16384];

    int n_checks = 0;
    int n_err = 0;
    int ok_cnt, err_cnt, nd_cnt;
    logic [31:0] first_addr;
    logic seen_req;
    bit done = 0;

    always #10 clk = ~clk;

    rxd_ring_writer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ring_base_i(RING_BASE),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
        .rx_flags_i(rx_flags),
        .desc_req_o(desc_req), .desc_we_o(desc_we), .desc_addr_o(desc_addr),
        .desc_wdata_o(desc_wdata), .desc_rdata_i(desc_rdata),
        .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_data_o(buf_data),
        .irq_evt_o(irq_evt), .miss_cnt_o(miss_cnt)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (sw_we) desc_mem[sw_addr] <= sw_data;
        if (desc_req && desc_we) desc_mem[desc_addr[7:2]] <= desc_wdata;
        desc_rdata <= desc_mem[desc_addr[7:2]];
        if (buf_we) bufm[buf_addr[13:0]] <= buf_data;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            ok_cnt <= 0; err_cnt <= 0; nd_cnt <= 0;
            seen_req <= 1'b0; first_addr <= '0;
        end else begin
            if (irq_evt[0]) ok_cnt  <= ok_cnt + 1;
            if (irq_evt[1]) err_cnt <= err_cnt + 1;
            if (irq_evt[4]) nd_cnt  <= nd_cnt + 1;
            if (desc_req && !seen_req) begin
                seen_req   <= 1'b1;
                first_addr <= desc_addr;
            end
        end
    end

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(((k + 3 * seed) % 251) + 1);
    endfunction

    function automatic logic [31:0] own_word(input logic [12:0] size, input logic eor);
        return {1'b1, eor, 17'b0, size};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sw_write(input int word, input logic [31:0] data);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = 6'(word); sw_data = data;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic send(input int len, input logic fcs, input logic runt, input int seed);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pat(seed, k);
            rx_last  = (k == len - 1);
            rx_flags = (k == len - 1) ? {runt, fcs} : 2'b00;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_flags = 2'b00;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0;
        rx_flags = '0; sw_we = 1'b0; sw_addr = '0; sw_data = '0;
        for (int i = 0; i < 4; i++) begin
            sw_write(16 + 4 * i + 2, 32'(i * 32'h800));
            sw_write(16 + 4 * i, own_word(VECS[i].size, i == 3));
        end
        @(negedge clk);
        // R1: reset state
        check("R1 desc write in reset", {31'b0, desc_we}, 32'd0);
        check("R1 buf write in reset", {31'b0, buf_we}, 32'd0);
        check("R1 events in reset", {24'b0, irq_evt}, 32'd0);
        check("R1 miss count in reset", {16'b0, miss_cnt}, 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 R6 first read at ring base", first_addr, RING_BASE);
        check("R1 miss after reset", {16'b0, miss_cnt}, 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            int idx, lim, stored, po, pe;
            logic lng, res;
            logic [31:0] exp;
            idx    = v % 4;
            lim    = (VECS[v].size > 13'd2048) ? 2048 : int'(VECS[v].size);
            stored = (int'(VECS[v].len) < lim) ? int'(VECS[v].len) : lim;
            lng    = int'(VECS[v].len) > lim;
            res    = lng | VECS[v].fcs | VECS[v].runt;
            exp    = {1'b0, idx == 3, 7'b0, lng, res, VECS[v].runt, VECS[v].fcs,
                      6'b0, 13'(stored)};
            po = ok_cnt; pe = err_cnt;
            send(int'(VECS[v].len), VECS[v].fcs, VECS[v].runt, v);
            repeat (8) @(negedge clk);
            // R3 R4 R5 R6 R11: status written at the expected ring slot
            check($sformatf("R3 R4 R5 R6 R11 status vec %0d", v), desc_mem[16 + 4 * idx], exp);
            check($sformatf("R2 first byte vec %0d", v), {24'b0, bufm[idx * 2048]}, {24'b0, pat(v, 0)});
            check($sformatf("R2 last stored byte vec %0d", v),
                  {24'b0, bufm[idx * 2048 + stored - 1]}, {24'b0, pat(v, stored - 1)});
            if (lng)
                check($sformatf("R5 byte past limit untouched vec %0d", v),
                      {24'b0, bufm[idx * 2048 + stored]}, 32'd0);
            check($sformatf("R7 ok events vec %0d", v), 32'(ok_cnt - po), res ? 32'd0 : 32'd1);
            check($sformatf("R7 err events vec %0d", v), 32'(err_cnt - pe), res ? 32'd1 : 32'd0);
            if (v + 4 < NVEC)
                sw_write(16 + 4 * idx, own_word(VECS[v + 4].size, idx == 3));
        end

        // R8: slot 0 is no longer owned; frame must be dropped
        begin
            logic [31:0] st0;
            logic [7:0] b0;
            int po, pe;
            st0 = desc_mem[16]; b0 = bufm[0]; po = ok_cnt; pe = err_cnt;
            send(10, 1'b0, 1'b0, 20);
            repeat (8) @(negedge clk);
            check("R8 miss count", {16'b0, miss_cnt}, 32'd1);
            check("R8 no-descriptor event", 32'(nd_cnt), 32'd1);
            check("R8 status untouched", desc_mem[16], st0);
            check("R8 buffer untouched", {24'b0, bufm[0]}, {24'b0, b0});
            check("R8 no completion events", 32'(ok_cnt - po + err_cnt - pe), 32'd0);
        end

        // R9: hand slot 0 back; polling picks it up, same index
        sw_write(16, own_word(13'd1536, 1'b0));
        repeat (6) @(negedge clk);
        send(8, 1'b0, 1'b0, 21);
        repeat (8) @(negedge clk);
        check("R9 R8 status after handback", desc_mem[16], 32'd8);
        check("R9 byte stored after handback", {24'b0, bufm[0]}, {24'b0, pat(21, 0)});

        // R10: size field above the cap acts as 2048
        sw_write(20, own_word(13'd4000, 1'b0));
        repeat (6) @(negedge clk);
        send(2100, 1'b0, 1'b0, 22);
        repeat (8) @(negedge clk);
        check("R10 clamped length", desc_mem[20], {9'b0, 1'b1, 1'b1, 2'b0, 6'b0, 13'd2048});
        check("R10 last stored byte", {24'b0, bufm[2048 + 2047]}, {24'b0, pat(22, 2047)});
        check("R8 miss count stable", {16'b0, miss_cnt}, 32'd1);

        done = 1;
        finish_run();
    end
endmodule